// File: doc/BRIEF.md
# Staggered Four-Lamp Schedule Sequencer

This block drives four indicator lamps through a fixed schedule that repeats every 14 seconds. A prescaler divides the system clock into a pulse that lasts one cycle and comes once per second. A slot counter steps through the fourteen one-second slots of a frame on each pulse. Each lamp is lit during its own window of consecutive slots. The first lamp stays lit for one slot, the second for two, the third for three and the fourth for four. Every window is preceded by one dark slot, so at most one lamp is ever lit.

The lamp outputs are active low and registered. They change only on a clock edge where the per-second pulse is present. The number of clock cycles per second is a parameter. Its default is 50,000,000, which suits a 50 MHz clock. The lamp count is also a parameter, and the frame length and the slot windows are derived from it.

Top module: `led_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, all `led_n` bits become 1 (lamps dark), and the schedule restarts at slot 0 once `rst` is released.
- R2: The slot advances exactly once every `CYCLES_PER_SEC` clock cycles. After reset release, slot `s` is in effect from the edge `s*CYCLES_PER_SEC` through the edge before `(s+1)*CYCLES_PER_SEC`.
- R3: A frame has 14 slots numbered 0 to 13. After slot 13 the counter returns to slot 0.
- R4: The outputs are active low, with 0 meaning lit. `led_n[0]` is 0 only during slot 1.
- R5: `led_n[1]` is 0 only during slots 3 and 4.
- R6: `led_n[2]` is 0 only during slots 6, 7 and 8.
- R7: `led_n[3]` is 0 only during slots 10 through 13, and it goes high at the frame wrap.
- R8: Outputs change only on the edge that ends a slot, never between slot boundaries, and no more than one `led_n` bit is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| led_n | output | N_LEDS (4) | Lamp drives, active low |

## Verification
The bench builds the block with `CYCLES_PER_SEC` = 5 and the default four lamps. A slot then lasts five cycles, so every clock edge across two whole frames can be compared with the schedule, including both frame wraps. This exposes any glitch inside a slot, any slot-boundary error of one cycle, and the way the block restarts after a reset asserted in mid-frame, all within a few hundred cycles.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

    // first slot in which lamp k is lit: 1, 3, 6, 10, ...
    function automatic int lit_first(input int k);
        return ((k + 1) * (k + 2)) / 2;
    endfunction

    // last slot in which lamp k is lit (lamp k lit for k+1 slots)
    function automatic int lit_last(input int k);
        return lit_first(k) + k;
    endfunction

    // slots in a frame: each lamp contributes a gap slot plus its lit slots
    function automatic int frame_len(input int n);
        return (n * (n + 3)) / 2;
    endfunction

    function automatic int bits_for(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
    parameter int CYCLES_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import led_seq_pkg::*;

    localparam int CW = bits_for(CYCLES_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_SEC - 1);

    logic [CW-1:0] count;

    assign tick = (count == LAST);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (tick) count <= '0;
        else           count <= count + 1'b1;
    end
endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
    parameter int FRAME = 14,
    parameter int SW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [SW-1:0] slot,
    output logic [SW-1:0] slot_next
);
    localparam logic [SW-1:0] TOP = SW'(FRAME - 1);

    assign slot_next = (slot == TOP) ? '0 : slot + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)       slot <= '0;
        else if (tick) slot <= slot_next;
    end
endmodule

// File: rtl/led_window.sv
module led_window #(
    parameter int SW    = 4,
    parameter int FIRST = 1,
    parameter int LAST  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [SW-1:0] slot_next,
    output logic          lamp_n
);
    localparam logic [SW-1:0] LO = SW'(FIRST);
    localparam logic [SW-1:0] HI = SW'(LAST);

    logic lit_next;
    assign lit_next = (slot_next >= LO) && (slot_next <= HI);

    always_ff @(posedge clk) begin
        if (rst)       lamp_n <= 1'b1;
        else if (tick) lamp_n <= ~lit_next;
    end
endmodule

// File: rtl/led_sequencer.sv
module led_sequencer #(
    parameter int CYCLES_PER_SEC = 50_000_000,
    parameter int N_LEDS         = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [N_LEDS-1:0] led_n
);
    import led_seq_pkg::*;

    localparam int FRAME = frame_len(N_LEDS);
    localparam int SW    = bits_for(FRAME);

    logic          tick;
    logic [SW-1:0] slot;
    logic [SW-1:0] slot_next;

    sec_prescaler #(.CYCLES_PER_SEC(CYCLES_PER_SEC)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    slot_counter #(.FRAME(FRAME), .SW(SW)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .slot     (slot),
        .slot_next(slot_next)
    );

    for (genvar k = 0; k < N_LEDS; k++) begin : g_lamp
        led_window #(
            .SW   (SW),
            .FIRST(lit_first(k)),
            .LAST (lit_last(k))
        ) u_win (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .slot_next(slot_next),
            .lamp_n   (led_n[k])
        );
    end
endmodule

// File: rtl/led_sequencer_chk.sv
module led_sequencer_chk #(
    parameter int N_LEDS = 4,
    parameter int SW     = 4,
    parameter int FRAME  = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [SW-1:0]     slot,
    input logic [N_LEDS-1:0] led_n
);
    // R1
    reset_dark_chk: assert property (@(posedge clk)
        rst |=> (&led_n) && (slot == '0));

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(slot));

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(slot) < FRAME);

    // R3
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && int'(slot) == FRAME - 1) |=> (slot == '0));

    // R8
    lamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(led_n));

    // R8
    one_lit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~led_n) <= 1);

    // R7
    last_lamp_on_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && int'(slot) == FRAME - 5) |=> !led_n[N_LEDS-1]);
endmodule

bind led_sequencer led_sequencer_chk #(
    .N_LEDS(N_LEDS),
    .SW    (SW),
    .FRAME (FRAME)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .slot (slot),
    .led_n(led_n)
);

// File: tb/sim_led_sequencer.sv
module sim_led_sequencer;
    localparam int CPS   = 5;
    localparam int NL    = 4;
    localparam int FRAME = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] led_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    led_sequencer #(.CYCLES_PER_SEC(CPS), .N_LEDS(NL)) u0 (
        .clk  (clk),
        .rst  (rst),
        .led_n(led_n)
    );

    // expected active-low pattern for a slot, from R4..R7
    function automatic logic [NL-1:0] expect_leds(input int s);
        logic [NL-1:0] e = '1;
        if (s == 1)             e[0] = 1'b0; // R4
        if (s >= 3 && s <= 4)   e[1] = 1'b0; // R5
        if (s >= 6 && s <= 8)   e[2] = 1'b0; // R6
        if (s >= 10 && s <= 13) e[3] = 1'b0; // R7
        return e;
    endfunction

    function automatic string req_of(input logic [NL-1:0] got, input logic [NL-1:0] exp);
        logic [NL-1:0] d = got ^ exp;
        if (d[0]) return "R4";
        if (d[1]) return "R5";
        if (d[2]) return "R6";
        if (d[3]) return "R7";
        return "R8";
    endfunction

    task automatic check(input string req, input logic [NL-1:0] got, input logic [NL-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: led_n=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // R1: reset drives all lamps dark
    task automatic test_reset_state();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1", led_n, '1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", led_n, '1);
    endtask

    // R2, R3, R4..R8: every edge over n_edges cycles after release
    task automatic test_schedule(input int n_edges);
        for (int n = 1; n <= n_edges; n++) begin
            logic [NL-1:0] exp;
            int s;
            @(posedge clk);
            #2;
            s = (n / CPS) % FRAME;
            exp = expect_leds(s);
            check(((n % CPS) == 0) ? "R2" : req_of(led_n, exp), led_n, exp);
        end
    endtask

    // R1: reset in mid-frame, then schedule restarts from slot 0 (R3 wrap too)
    task automatic test_mid_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R1", led_n, '1);
        @(negedge clk);
        rst = 1'b0;
        test_schedule(FRAME * CPS + 2 * CPS);
    endtask

    initial begin
        test_reset_state();
        test_schedule(2 * FRAME * CPS + CPS);   // two full frames plus a slot
        // now in mid-frame past one wrap (R3); move into lamp 2's window
        repeat (6 * CPS) @(posedge clk);
        test_mid_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end
endmodule